// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block renames a group of up to four instructions in a single cycle. Each slot carries two architectural source registers, one architectural destination and a flag saying whether that destination is written. The block holds the speculative map from architectural to physical registers, together with a queue of unallocated physical registers. For every slot it returns physical source tags, a newly allocated physical destination and the physical register the destination displaces. The displaced register is handed on so that a later commit stage can free it.

Dependencies inside the group are resolved before the map table result is used. A source that names a register written by an older slot in the same group takes that slot's new physical register. When several older slots write it, the nearest one wins. Sources with no such writer read the map as it stood before the group. The map is written at the clock edge, and if two slots name the same destination the youngest one sets the entry. If the queue holds fewer registers than the group needs, the whole group is held back for that cycle and nothing changes.

Outputs are combinational from the inputs and the current state. State advances at the rising edge only when the group is accepted. There are 32 architectural registers, 64 physical registers and a group width of 4, all set by package constants.

Top module: `rnm_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i, so a source naming register i with no older writer in its group returns tag i.
- R2: A source with no older writer of the same architectural register in its group returns the map-table entry that held before the group.
- R3: A source that names a register written by an older slot of the same group returns the new physical register of the nearest such older slot.
- R4: Each slot with its write flag set receives a distinct free register. Registers are taken from the queue in slot order, and the first group after reset receives 32, 33, 34 and so on. The queue count drops by the number of writes in an accepted group.
- R5: After an accepted group, the map entry of every written destination holds the register allocated to the youngest slot in the group that wrote it.
- R6: Each writing slot reports as its displaced register the mapping its destination had just before that slot: the new register of the nearest older slot writing the same destination, or else the map-table entry.
- R7: When grp_valid is high and the queue holds fewer registers than the group's writes, grp_stall is 1 and grp_accept is 0. The map and the queue stay unchanged, so a later group sees the state as it was before the stalled one.
- R8: A slot with its write flag at 0 allocates no register and does not change the map. A group with no writes is accepted even when the queue is empty.
- R9: A source that names its own slot's destination reads the older mapping and never its own new register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A rename group is presented this cycle |
| src_a | input | 4x5 | First architectural source per slot |
| src_b | input | 4x5 | Second architectural source per slot |
| dst_arch | input | 4x5 | Architectural destination per slot |
| dst_wr | input | 4 | Slot writes its destination |
| grp_stall | output | 1 | Group held back for lack of free registers |
| grp_accept | output | 1 | Group renamed and state updated at this edge |
| psrc_a | output | 4x6 | Physical tag for the first source per slot |
| psrc_b | output | 4x6 | Physical tag for the second source per slot |
| pdst | output | 4x6 | Newly allocated physical destination per slot |
| pdst_prev | output | 4x6 | Displaced physical register per writing slot |

## Verification
Two functions can coincide in one slot: the in-group forwarding path and the map-table read. The same applies to a slot's own allocation and its displaced-register output. This is provoked by chains where one slot reads the destination of an older slot and also writes the same register, and by groups where all four slots write and read one register. The bench judges each case against a slot-by-slot sequential model. It also drains the queue to two entries. A three-write group then has to stall with the map left untouched, and this is confirmed by the reads of the group that follows.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

    localparam int ARCH_REGS = 32;
    localparam int PHYS_REGS = 64;
    localparam int GROUP_W   = 4;

    localparam int AW       = $clog2(ARCH_REGS);
    localparam int PW       = $clog2(PHYS_REGS);
    localparam int FL_DEPTH = PHYS_REGS - ARCH_REGS;
    localparam int FL_PW    = $clog2(FL_DEPTH);
    localparam int FL_CW    = $clog2(FL_DEPTH + 1);
    localparam int GW_CW    = $clog2(GROUP_W + 1);

    typedef logic [AW-1:0] arch_t;
    typedef logic [PW-1:0] phys_t;

    typedef struct packed {
        logic  wr;
        arch_t dst;
        arch_t src_b;
        arch_t src_a;
    } slot_req_t;

    typedef struct packed {
        phys_t ps_a;
        phys_t ps_b;
        phys_t pd;
        phys_t pd_prev;
    } slot_map_t;

    function automatic int wrap_fl(input int idx);
        return (idx >= FL_DEPTH) ? idx - FL_DEPTH : idx;
    endfunction

endpackage

// File: rtl/rnm_free_list.sv
module rnm_free_list
    import rnm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pop,
    input  logic [GW_CW-1:0]       pop_n,
    output phys_t [GROUP_W-1:0]    win,
    output logic [FL_CW-1:0]       count
);

    phys_t            mem [FL_DEPTH];
    logic [FL_PW-1:0] head;
    logic [FL_PW-1:0] head_nxt;

    always_comb begin
        head_nxt = FL_PW'(wrap_fl(int'(head) + int'(pop_n)));
    end

    generate
        for (genvar i = 0; i < GROUP_W; i++) begin : g_win
            always_comb begin
                win[i] = mem[wrap_fl(int'(head) + i)];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FL_DEPTH; i++) begin
                mem[i] <= PW'(ARCH_REGS + i);
            end
            head  <= '0;
            count <= FL_CW'(FL_DEPTH);
        end else if (pop) begin
            head  <= head_nxt;
            count <= count - FL_CW'(pop_n);
        end
    end

endmodule

// File: rtl/rnm_map_table.sv
module rnm_map_table
    import rnm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  slot_req_t [GROUP_W-1:0]   req,
    output phys_t     [GROUP_W-1:0]   rd_a,
    output phys_t     [GROUP_W-1:0]   rd_b,
    output phys_t     [GROUP_W-1:0]   rd_d,
    input  logic                      upd,
    input  phys_t     [GROUP_W-1:0]   new_p
);

    phys_t map [ARCH_REGS];

    generate
        for (genvar k = 0; k < GROUP_W; k++) begin : g_rd
            always_comb begin
                rd_a[k] = map[req[k].src_a];
                rd_b[k] = map[req[k].src_b];
                rd_d[k] = map[req[k].dst];
            end
        end
    endgenerate

    // Ascending slot order: the youngest writer's assignment lands last.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                map[i] <= PW'(i);
            end
        end else if (upd) begin
            for (int j = 0; j < GROUP_W; j++) begin
                if (req[j].wr) begin
                    map[req[j].dst] <= new_p[j];
                end
            end
        end
    end

endmodule

// File: rtl/rnm_group_bypass.sv
module rnm_group_bypass
    import rnm_pkg::*;
(
    input  slot_req_t [GROUP_W-1:0] req,
    input  phys_t     [GROUP_W-1:0] rd_a,
    input  phys_t     [GROUP_W-1:0] rd_b,
    input  phys_t     [GROUP_W-1:0] rd_d,
    input  phys_t     [GROUP_W-1:0] win,
    output slot_map_t [GROUP_W-1:0] res,
    output logic [GW_CW-1:0]        n_wr
);

    always_comb begin
        int off;
        off = 0;
        for (int k = 0; k < GROUP_W; k++) begin
            if (req[k].wr) begin
                res[k].pd = win[off];
                off = off + 1;
            end else begin
                res[k].pd = '0;
            end
            res[k].ps_a    = rd_a[k];
            res[k].ps_b    = rd_b[k];
            res[k].pd_prev = rd_d[k];
            // Scan older slots oldest-first so the nearest writer overrides.
            for (int j = 0; j < GROUP_W; j++) begin
                if (j < k && req[j].wr) begin
                    if (req[j].dst == req[k].src_a) res[k].ps_a    = res[j].pd;
                    if (req[j].dst == req[k].src_b) res[k].ps_b    = res[j].pd;
                    if (req[j].dst == req[k].dst)   res[k].pd_prev = res[j].pd;
                end
            end
        end
        n_wr = GW_CW'(off);
    end

endmodule

// File: rtl/rnm_rename.sv
module rnm_rename
    import rnm_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            grp_valid,
    input  logic [GROUP_W-1:0][AW-1:0]      src_a,
    input  logic [GROUP_W-1:0][AW-1:0]      src_b,
    input  logic [GROUP_W-1:0][AW-1:0]      dst_arch,
    input  logic [GROUP_W-1:0]              dst_wr,
    output logic                            grp_stall,
    output logic                            grp_accept,
    output logic [GROUP_W-1:0][PW-1:0]      psrc_a,
    output logic [GROUP_W-1:0][PW-1:0]      psrc_b,
    output logic [GROUP_W-1:0][PW-1:0]      pdst,
    output logic [GROUP_W-1:0][PW-1:0]      pdst_prev
);

    slot_req_t [GROUP_W-1:0] req;
    slot_map_t [GROUP_W-1:0] res;
    phys_t     [GROUP_W-1:0] rd_a;
    phys_t     [GROUP_W-1:0] rd_b;
    phys_t     [GROUP_W-1:0] rd_d;
    phys_t     [GROUP_W-1:0] win;
    phys_t     [GROUP_W-1:0] new_p;
    logic [GW_CW-1:0]        n_wr;
    logic [FL_CW-1:0]        fl_count;

    generate
        for (genvar k = 0; k < GROUP_W; k++) begin : g_slot
            always_comb begin
                req[k].wr    = dst_wr[k];
                req[k].dst   = dst_arch[k];
                req[k].src_a = src_a[k];
                req[k].src_b = src_b[k];
                psrc_a[k]    = res[k].ps_a;
                psrc_b[k]    = res[k].ps_b;
                pdst[k]      = res[k].pd;
                pdst_prev[k] = res[k].pd_prev;
                new_p[k]     = res[k].pd;
            end
        end
    endgenerate

    always_comb begin
        grp_stall  = grp_valid && (FL_CW'(n_wr) > fl_count);
        grp_accept = grp_valid && !grp_stall;
    end

    rnm_map_table u_map (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .rd_a  (rd_a),
        .rd_b  (rd_b),
        .rd_d  (rd_d),
        .upd   (grp_accept),
        .new_p (new_p)
    );

    rnm_free_list u_fl (
        .clk   (clk),
        .rst   (rst),
        .pop   (grp_accept),
        .pop_n (n_wr),
        .win   (win),
        .count (fl_count)
    );

    rnm_group_bypass u_byp (
        .req  (req),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .rd_d (rd_d),
        .win  (win),
        .res  (res),
        .n_wr (n_wr)
    );

endmodule

// File: rtl/rnm_rename_chk.sv
module rnm_rename_chk
    import rnm_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        grp_stall,
    input logic                        grp_accept,
    input logic [GROUP_W-1:0][AW-1:0]  src_a,
    input logic [GROUP_W-1:0][AW-1:0]  dst_arch,
    input logic [GROUP_W-1:0]          dst_wr,
    input logic [GROUP_W-1:0][PW-1:0]  psrc_a,
    input logic [GROUP_W-1:0][PW-1:0]  pdst,
    input logic [GW_CW-1:0]            n_wr,
    input logic [FL_CW-1:0]            fl_count
);

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        grp_stall |-> !grp_accept); // R7

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !grp_accept |=> $stable(fl_count)); // R7

    AST_COUNT_DROPS: assert property (@(posedge clk) disable iff (rst)
        grp_accept |=> (fl_count == $past(fl_count) - FL_CW'($past(n_wr)))); // R4

    AST_NO_WRITE_NO_POP: assert property (@(posedge clk) disable iff (rst)
        (grp_accept && dst_wr == '0) |=> $stable(fl_count)); // R8

    generate
        for (genvar i = 0; i < GROUP_W; i++) begin : g_i
            AST_OWN_SRC_OLD: assert property (@(posedge clk) disable iff (rst)
                (grp_accept && dst_wr[i] && src_a[i] == dst_arch[i])
                |-> (psrc_a[i] != pdst[i])); // R9
            for (genvar j = i + 1; j < GROUP_W; j++) begin : g_j
                AST_ALLOC_UNIQUE: assert property (@(posedge clk) disable iff (rst)
                    (grp_accept && dst_wr[i] && dst_wr[j]) |-> (pdst[i] != pdst[j])); // R4
            end
        end
    endgenerate

endmodule

bind rnm_rename rnm_rename_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .grp_stall  (grp_stall),
    .grp_accept (grp_accept),
    .src_a      (src_a),
    .dst_arch   (dst_arch),
    .dst_wr     (dst_wr),
    .psrc_a     (psrc_a),
    .pdst       (pdst),
    .n_wr       (n_wr),
    .fl_count   (fl_count)
);

// File: tb/rnm_rename_tb.sv
`timescale 1ns/1ps
module rnm_rename_tb;
    import rnm_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic grp_valid = 1'b0;
    logic [GROUP_W-1:0][AW-1:0] src_a = '0;
    logic [GROUP_W-1:0][AW-1:0] src_b = '0;
    logic [GROUP_W-1:0][AW-1:0] dst_arch = '0;
    logic [GROUP_W-1:0]         dst_wr = '0;
    logic grp_stall, grp_accept;
    logic [GROUP_W-1:0][PW-1:0] psrc_a, psrc_b, pdst, pdst_prev;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int map_m [ARCH_REGS];
    int next_m;
    int free_m;

    always #2 clk = ~clk;

    rnm_rename u_dut (
        .clk(clk), .rst(rst), .grp_valid(grp_valid),
        .src_a(src_a), .src_b(src_b), .dst_arch(dst_arch), .dst_wr(dst_wr),
        .grp_stall(grp_stall), .grp_accept(grp_accept),
        .psrc_a(psrc_a), .psrc_b(psrc_b), .pdst(pdst), .pdst_prev(pdst_prev)
    );

    // Slot encoding, 16 bits per slot, slot 0 in bits 15:0:
    // {write flag, destination, source b, source a}
    localparam int NVEC = 4;
    localparam logic [63:0] VEC [NVEC] = '{
        // chain: r3, then r4 from r3, then r3 again, then a reader
        {1'b0,5'd0,5'd5,5'd3,    1'b1,5'd3,5'd3,5'd4,
         1'b1,5'd4,5'd3,5'd3,    1'b1,5'd3,5'd2,5'd1},
        // own-destination source, hole slot, double writer of r10
        {1'b1,5'd10,5'd10,5'd10, 1'b1,5'd10,5'd10,5'd3,
         1'b0,5'd9,5'd31,5'd0,   1'b1,5'd3,5'd4,5'd3},
        // four writers of r7, each reading r7
        {1'b1,5'd7,5'd7,5'd7,    1'b1,5'd7,5'd7,5'd7,
         1'b1,5'd7,5'd7,5'd7,    1'b1,5'd7,5'd7,5'd7},
        // readers only
        {1'b0,5'd0,5'd31,5'd0,   1'b0,5'd0,5'd1,5'd2,
         1'b0,5'd0,5'd4,5'd3,    1'b0,5'd0,5'd10,5'd7}
    };

    function automatic logic [15:0] mk(input logic w, input int d, input int b, input int a);
        return {w, AW'(d), AW'(b), AW'(a)};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < ARCH_REGS; i++) map_m[i] = i;
        next_m = ARCH_REGS;
        free_m = FL_DEPTH;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        grp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // Drive one group at a falling edge, check before the rising edge,
    // then commit the sequential model if the group was accepted.
    task automatic run_group(input logic [63:0] v);
        int tmp [ARCH_REGS];
        int nf, nwr;
        bit stall_e;
        bit byp_a, byp_b, hole;
        @(negedge clk);
        grp_valid = 1'b1;
        nwr = 0;
        for (int k = 0; k < GROUP_W; k++) begin
            src_a[k]    = v[16*k +: 5];
            src_b[k]    = v[16*k+5 +: 5];
            dst_arch[k] = v[16*k+10 +: 5];
            dst_wr[k]   = v[16*k+15];
            if (v[16*k+15]) nwr++;
        end
        #1;
        stall_e = (nwr > free_m);
        chk("R7", "grp_stall", int'(grp_stall), int'(stall_e));
        chk("R7", "grp_accept", int'(grp_accept), int'(!stall_e));
        if (!stall_e) begin
            tmp  = map_m;
            nf   = next_m;
            hole = 1'b0;
            for (int k = 0; k < GROUP_W; k++) begin
                int a, b, d;
                a = int'(src_a[k]);
                b = int'(src_b[k]);
                d = int'(dst_arch[k]);
                byp_a = (tmp[a] != map_m[a]);
                byp_b = (tmp[b] != map_m[b]);
                if (dst_wr[k] && a == d && !byp_a)
                    chk("R9", $sformatf("slot%0d psrc_a", k), int'(psrc_a[k]), tmp[a]);
                else if (byp_a)
                    chk("R3", $sformatf("slot%0d psrc_a", k), int'(psrc_a[k]), tmp[a]);
                else if (map_m[a] != a)
                    chk("R5", $sformatf("slot%0d psrc_a", k), int'(psrc_a[k]), tmp[a]);
                else
                    chk("R2", $sformatf("slot%0d psrc_a", k), int'(psrc_a[k]), tmp[a]);
                if (byp_b)
                    chk("R3", $sformatf("slot%0d psrc_b", k), int'(psrc_b[k]), tmp[b]);
                else
                    chk("R2", $sformatf("slot%0d psrc_b", k), int'(psrc_b[k]), tmp[b]);
                if (dst_wr[k]) begin
                    chk(hole ? "R8" : "R4", $sformatf("slot%0d pdst", k), int'(pdst[k]), nf);
                    chk("R6", $sformatf("slot%0d pdst_prev", k), int'(pdst_prev[k]), tmp[d]);
                    tmp[d] = nf;
                    nf++;
                end else begin
                    hole = 1'b1;
                end
            end
        end
        @(posedge clk);
        if (!stall_e) begin
            map_m  = tmp;
            next_m = nf;
            free_m = free_m - nwr;
        end
        @(negedge clk);
        grp_valid = 1'b0;
        dst_wr    = '0;
    endtask

    initial begin
        model_reset();
        do_reset();
        #1;
        // R7: idle reset state, no group presented
        chk("R7", "reset grp_stall", int'(grp_stall), 0);
        chk("R7", "reset grp_accept", int'(grp_accept), 0);

        // R1: identity mapping straight after reset
        @(negedge clk);
        for (int k = 0; k < GROUP_W; k++) begin
            src_a[k] = AW'(k + 20);
            src_b[k] = AW'(31 - k);
        end
        #1;
        for (int k = 0; k < GROUP_W; k++) begin
            chk("R1", $sformatf("slot%0d psrc_a", k), int'(psrc_a[k]), k + 20);
            chk("R1", $sformatf("slot%0d psrc_b", k), int'(psrc_b[k]), 31 - k);
        end

        // Table walk: R2, R3, R4, R5, R6, R8, R9
        for (int n = 0; n < NVEC; n++) run_group(VEC[n]);

        // Drain the queue: 22 left, five full groups leave 2 (R4, R5)
        for (int g = 0; g < 5; g++)
            run_group({mk(1, 23, g, 23), mk(1, 22, 22, g),
                       mk(1, 21, 21, 21), mk(1, 20, 20, 3)});
        chk("R4", "model queue level", free_m, 2);

        // R7: three writes against two free registers must stall
        run_group({mk(0, 0, 0, 0), mk(1, 21, 1, 1), mk(1, 22, 2, 2), mk(1, 20, 3, 3)});
        // R7: map unchanged by the stalled group, seen through plain reads
        run_group({mk(0, 0, 23, 22), mk(0, 0, 21, 20), mk(0, 0, 7, 3), mk(0, 0, 10, 4)});
        // R5: two writers of one register, youngest wins; queue empties
        run_group({mk(0, 0, 0, 0), mk(1, 5, 5, 5), mk(0, 0, 0, 0), mk(1, 5, 6, 5)});
        run_group({mk(0, 0, 0, 0), mk(0, 0, 0, 0), mk(0, 0, 5, 6), mk(0, 0, 5, 5)});
        // R7: a single write now stalls; R8: a write-free group still passes
        run_group({mk(0, 0, 0, 0), mk(0, 0, 0, 0), mk(1, 9, 9, 9), mk(0, 0, 0, 0)});
        run_group({mk(0, 0, 9, 5), mk(0, 0, 0, 0), mk(0, 0, 9, 9), mk(0, 0, 20, 7)});

        // R1 and R4: reset restores identity map and full queue
        do_reset();
        run_group(VEC[0]);
        @(negedge clk);
        for (int k = 0; k < GROUP_W; k++) begin
            src_a[k] = AW'(k + 8);
            src_b[k] = AW'(k + 8);
        end
        #1;
        for (int k = 0; k < GROUP_W; k++)
            chk("R1", $sformatf("post-reset slot%0d psrc_a", k), int'(psrc_a[k]), k + 8);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule